// File: doc/BRIEF.md
# Microwire Serial Memory Slave

This block is a synthesizable model of a three-wire serial memory slave. A controller selects it with a chip-select line and clocks instructions into it on a serial data line. The block decodes each instruction and serves reads and programming requests from an internal register array. It runs entirely in a fast system clock domain. The chip select, serial clock and data inputs are brought into that domain through two-flop synchronizers, and the block acts on the edges it sees there.

The array can be viewed as words or as bytes, chosen by an organization input. A write-enable latch guards every instruction that changes the array. A programming operation takes a fixed number of system clocks. While it runs, the block shows a busy/ready flag on its data output whenever chip select is high. Reads insert one zero bit before the data and then keep streaming at rising addresses, wrapping at the top of the array, until chip select drops.

Top module: `mwMemSlave`

## Requirements
- R1: An instruction begins with the first 1 sampled while chip select is high; any 0 bits before it are ignored. Every bit is sampled on a rising serial clock edge while chip select is high. After the start bit come a 2-bit opcode and an address, each sent most significant bit first. The address is 6 bits in word view and 7 bits in byte view.
- R2: With the organization input high, the array is seen as 64 words of 16 bits. With it low, the array is seen as 128 bytes. Byte 2k is bits [7:0] of word k, and byte 2k+1 is bits [15:8].
- R3: Opcode 10 reads. After the last address bit, data out is 0 (a dummy bit). Each following serial clock rise then presents the next data bit, most significant bit first.
- R4: After the last bit of a location, a read carries on with the next higher address. It wraps from the top address (63 or 127) to 0, for as long as chip select stays high.
- R5: The write-enable latch is clear after reset. Opcode 00 with the top address bits 11 sets it, and with 00 clears it. While the latch is clear, the write, erase, write-all and erase-all instructions leave the array unchanged.
- R6: Opcode 01 followed by data writes the addressed location when chip select falls. If more bits than the location width arrive, only the last bits count. If fewer arrive, the instruction is dropped.
- R7: Opcode 11 sets the addressed location to all ones. Opcode 00 with the top address bits 10 sets the whole array to all ones.
- R8: Opcode 00 with the top address bits 01, followed by data, writes that data to every location. In byte view, both bytes of every word receive it.
- R9: Programming starts on the falling edge of chip select and lasts PROG_CYCLES system clocks. If chip select is high during the program time, data out is driven 0. Once programming has finished, data out is driven 1, and it stays that way until a serial clock rise with chip select and data in both high. If programming ends while chip select is low, no status is shown afterwards.
- R10: Instructions clocked in while a program is in progress have no effect.
- R11: The output enable is low whenever chip select is low. It is also low while chip select is high and the block is neither reading nor showing status.
- R12: After reset, every array bit reads 1, the write-enable latch is clear and the output enable is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csIn | input | 1 | Chip select, asynchronous |
| skIn | input | 1 | Serial clock, asynchronous |
| diIn | input | 1 | Serial data in, asynchronous |
| orgIn | input | 1 | Organization: 1 word view, 0 byte view |
| doOut | output | 1 | Serial data out / ready-busy flag |
| doOe | output | 1 | Output enable for doOut |

## Verification
Random writes at random addresses, each with random data, followed by a long wrapping read, show whether the address path, the data lanes and the increment logic each keep locations apart. Directed sequences separate the cases that random stimulus rarely produces. These are writes with too many or too few data bits, instructions sent before the write-enable latch is set or after it is cleared, and instructions sent during a program. They also cover status shown across the end of a program, and program completion with chip select low. Byte-view writes are read back in word view to confirm lane placement. Write-all and erase-all are checked in both views.

// File: rtl/mwPkg.sv
package mwPkg;
  typedef enum logic [2:0] {
    S_IDLE, S_HDR, S_DEC, S_DATA, S_READ, S_WAIT, S_BUSY
  } mwState_e;

  typedef enum logic [2:0] {
    PK_NONE, PK_WORD, PK_ALL, PK_ERASE, PK_ERALL
  } mwProg_e;

  localparam logic [1:0] OP_EXT   = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_ERASE = 2'b11;

  localparam logic [1:0] SUB_WDS  = 2'b00;
  localparam logic [1:0] SUB_WRAL = 2'b01;
  localparam logic [1:0] SUB_ERAL = 2'b10;
  localparam logic [1:0] SUB_WEN  = 2'b11;

  typedef struct packed {
    logic hdrClr;
    logic hdrShift;
    logic addrLoad;
    logic dataShift;
    logic rdLoad;
    logic rdShift;
    logic rdNext;
    logic progWord;
    logic progAll;
    logic eraseWord;
    logic eraseAll;
  } mwStrobe_t;
endpackage

// File: rtl/mwSync.sv
module mwSync #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] asyncIn,
  output logic [N-1:0] syncOut
);
  for (genvar i = 0; i < N; i++) begin : gSync
    logic meta, held;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        meta <= 1'b0;
        held <= 1'b0;
      end else begin
        meta <= asyncIn[i];
        held <= meta;
      end
    end
    assign syncOut[i] = held;
  end
endmodule

// File: rtl/mwData.sv
module mwData
  import mwPkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int WADDR_W = 6
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      orgS,
  input  logic      diS,
  input  mwStrobe_t stb,
  output logic [1:0] opCode,
  output logic [1:0] subOp,
  output logic      outBit
);
  localparam int BYTE_W  = WORD_W / 2;
  localparam int DEPTH   = 1 << WADDR_W;
  localparam int BADDR_W = WADDR_W + 1;
  localparam int HDR_W   = BADDR_W + 2;

  logic [HDR_W-1:0]   hdr;
  logic [BADDR_W-1:0] addr, hdrAddr, addrInc;
  logic [WADDR_W-1:0] wordIdx;
  logic [WORD_W-1:0]  dataSr, outSr, rdFirst, rdNxt;
  logic [WORD_W-1:0]  mem [DEPTH];

  function automatic logic [WORD_W-1:0] fetch(input logic [BADDR_W-1:0] a);
    logic [WORD_W-1:0] w;
    if (orgS) return mem[a[WADDR_W-1:0]];
    w = mem[a[BADDR_W-1:1]];
    return {(a[0] ? w[WORD_W-1:BYTE_W] : w[BYTE_W-1:0]), {BYTE_W{1'b0}}};
  endfunction

  assign opCode  = orgS ? hdr[WADDR_W+1:WADDR_W] : hdr[BADDR_W+1:BADDR_W];
  assign subOp   = orgS ? hdr[WADDR_W-1:WADDR_W-2] : hdr[BADDR_W-1:BADDR_W-2];
  assign hdrAddr = orgS ? {1'b0, hdr[WADDR_W-1:0]} : hdr[BADDR_W-1:0];
  assign addrInc = orgS ? {1'b0, addr[WADDR_W-1:0] + WADDR_W'(1)} : addr + BADDR_W'(1);
  assign wordIdx = orgS ? addr[WADDR_W-1:0] : addr[BADDR_W-1:1];

  always_comb begin
    rdFirst = fetch(hdrAddr);
    rdNxt   = fetch(addrInc);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hdr    <= '0;
      addr   <= '0;
      dataSr <= '0;
      outSr  <= '0;
      outBit <= 1'b0;
    end else begin
      if (stb.hdrClr)    hdr <= '0;
      if (stb.hdrShift)  hdr <= {hdr[HDR_W-2:0], diS};
      if (stb.addrLoad)  addr <= hdrAddr;
      if (stb.dataShift) dataSr <= {dataSr[WORD_W-2:0], diS};
      if (stb.rdLoad) begin
        outSr  <= rdFirst;
        outBit <= 1'b0;
      end
      if (stb.rdShift) begin
        outBit <= outSr[WORD_W-1];
        outSr  <= {outSr[WORD_W-2:0], 1'b0};
      end
      if (stb.rdNext) begin
        addr   <= addrInc;
        outBit <= rdNxt[WORD_W-1];
        outSr  <= {rdNxt[WORD_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (stb.eraseAll) mem[i] <= '1;
        if (stb.progAll)  mem[i] <= orgS ? dataSr : {2{dataSr[BYTE_W-1:0]}};
      end
      if (stb.eraseWord) begin
        if (orgS)         mem[wordIdx] <= '1;
        else if (addr[0]) mem[wordIdx][WORD_W-1:BYTE_W] <= '1;
        else              mem[wordIdx][BYTE_W-1:0] <= '1;
      end
      if (stb.progWord) begin
        if (orgS)         mem[wordIdx] <= dataSr;
        else if (addr[0]) mem[wordIdx][WORD_W-1:BYTE_W] <= dataSr[BYTE_W-1:0];
        else              mem[wordIdx][BYTE_W-1:0] <= dataSr[BYTE_W-1:0];
      end
    end
  end
endmodule

// File: rtl/mwCtrl.sv
module mwCtrl
  import mwPkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int WADDR_W     = 6,
  parameter int PROG_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csS,
  input  logic       skS,
  input  logic       diS,
  input  logic       orgS,
  input  logic [1:0] opCode,
  input  logic [1:0] subOp,
  input  logic       outBit,
  output mwStrobe_t  stb,
  output logic       doOut,
  output logic       doOe,
  output logic       busy,
  output logic       wel
);
  localparam int CNT_W  = $clog2(WORD_W) + 2;
  localparam int BUSY_W = $clog2(PROG_CYCLES + 1);

  mwState_e state;
  mwProg_e  kind;
  logic [CNT_W-1:0]  cnt, dataCnt, rdLeft, hdrLen, dataLen;
  logic [BUSY_W-1:0] busyCnt;
  logic skPrev, csPrev, skAct, csFall, statusOn, progReady, startProg;

  assign skAct   = skS && !skPrev && csS;
  assign csFall  = csPrev && !csS;
  assign hdrLen  = orgS ? CNT_W'(WADDR_W + 2) : CNT_W'(WADDR_W + 3);
  assign dataLen = orgS ? CNT_W'(WORD_W) : CNT_W'(WORD_W / 2);
  assign busy    = (state == S_BUSY);

  assign progReady = wel &&
    ((state == S_DATA && dataCnt >= dataLen && (kind == PK_WORD || kind == PK_ALL)) ||
     (state == S_WAIT && (kind == PK_ERASE || kind == PK_ERALL)));
  assign startProg = csFall && progReady;

  assign doOe  = csS && (statusOn || state == S_READ);
  assign doOut = statusOn ? !busy : outBit;

  always_comb begin
    stb = '0;
    unique case (state)
      S_IDLE: stb.hdrClr    = skAct && diS;
      S_HDR:  stb.hdrShift  = skAct;
      S_DEC: begin
        stb.addrLoad = 1'b1;
        stb.rdLoad   = (opCode == OP_READ);
      end
      S_DATA: stb.dataShift = skAct;
      S_READ: begin
        stb.rdShift = skAct && (rdLeft != '0);
        stb.rdNext  = skAct && (rdLeft == '0);
      end
      default: ;
    endcase
    if (startProg) begin
      stb.progWord  = (kind == PK_WORD);
      stb.progAll   = (kind == PK_ALL);
      stb.eraseWord = (kind == PK_ERASE);
      stb.eraseAll  = (kind == PK_ERALL);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      kind     <= PK_NONE;
      cnt      <= '0;
      dataCnt  <= '0;
      rdLeft   <= '0;
      busyCnt  <= '0;
      statusOn <= 1'b0;
      wel      <= 1'b0;
      skPrev   <= 1'b0;
      csPrev   <= 1'b0;
    end else begin
      skPrev <= skS;
      csPrev <= csS;
      if (skAct && diS && state != S_BUSY) statusOn <= 1'b0;
      if (state == S_BUSY) begin
        if (busyCnt == '0) begin
          state <= S_IDLE;
          if (!csS) statusOn <= 1'b0;
        end else begin
          busyCnt <= busyCnt - BUSY_W'(1);
        end
      end else if (csFall) begin
        kind <= PK_NONE;
        if (startProg) begin
          state    <= S_BUSY;
          busyCnt  <= BUSY_W'(PROG_CYCLES - 1);
          statusOn <= 1'b1;
        end else begin
          state    <= S_IDLE;
          statusOn <= 1'b0;
        end
      end else begin
        unique case (state)
          S_IDLE: if (skAct && diS) begin
            state <= S_HDR;
            cnt   <= '0;
          end
          S_HDR: if (skAct) begin
            if (cnt == hdrLen - CNT_W'(1)) state <= S_DEC;
            else                           cnt   <= cnt + CNT_W'(1);
          end
          S_DEC: begin
            dataCnt <= '0;
            unique case (opCode)
              OP_READ: begin
                state  <= S_READ;
                rdLeft <= dataLen;
              end
              OP_WRITE: begin
                state <= S_DATA;
                kind  <= PK_WORD;
              end
              OP_ERASE: begin
                state <= S_WAIT;
                kind  <= PK_ERASE;
              end
              default: begin
                state <= S_WAIT;
                unique case (subOp)
                  SUB_WEN:  wel <= 1'b1;
                  SUB_WDS:  wel <= 1'b0;
                  SUB_WRAL: begin
                    state <= S_DATA;
                    kind  <= PK_ALL;
                  end
                  default:  kind <= PK_ERALL;
                endcase
              end
            endcase
          end
          S_DATA: if (skAct && dataCnt != '1) dataCnt <= dataCnt + CNT_W'(1);
          S_READ: if (skAct) rdLeft <= (rdLeft == '0) ? dataLen - CNT_W'(1) : rdLeft - CNT_W'(1);
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/mwMemSlave.sv
module mwMemSlave
  import mwPkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int WADDR_W     = 6,
  parameter int PROG_CYCLES = 1000
) (
  input  logic clk,
  input  logic rstN,
  input  logic csIn,
  input  logic skIn,
  input  logic diIn,
  input  logic orgIn,
  output logic doOut,
  output logic doOe
);
  logic [3:0] syncVec;
  logic csS, skS, diS, orgS, busy, wel, outBit;
  logic [1:0] opCode, subOp;
  mwStrobe_t stb;

  mwSync #(.N(4)) uSync (
    .clk(clk), .rstN(rstN),
    .asyncIn({orgIn, diIn, skIn, csIn}),
    .syncOut(syncVec)
  );
  assign {orgS, diS, skS, csS} = syncVec;

  mwCtrl #(.WORD_W(WORD_W), .WADDR_W(WADDR_W), .PROG_CYCLES(PROG_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .csS(csS), .skS(skS), .diS(diS), .orgS(orgS),
    .opCode(opCode), .subOp(subOp), .outBit(outBit), .stb(stb),
    .doOut(doOut), .doOe(doOe), .busy(busy), .wel(wel)
  );

  mwData #(.WORD_W(WORD_W), .WADDR_W(WADDR_W)) uData (
    .clk(clk), .rstN(rstN), .orgS(orgS), .diS(diS), .stb(stb),
    .opCode(opCode), .subOp(subOp), .outBit(outBit)
  );
endmodule

// File: rtl/mwMemSlaveChk.sv
module mwMemSlaveChk (
  input logic clk,
  input logic rstN,
  input logic csS,
  input logic busy,
  input logic wel,
  input logic doOe,
  input logic doOut
);
  // R11: deselected block never drives
  a_r11_oe_needs_cs: assert property (@(posedge clk) disable iff (!rstN)
    !csS |-> !doOe);

  // R12: latch starts clear on the first cycle out of reset
  a_r12_wel_clear_at_start: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> !wel);

  // R9: a program begins only right after chip select drops
  a_r9_prog_on_cs_fall: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (!$past(csS) && $past(csS, 2)));

  // R9: selected during a program shows busy as 0
  a_r9_busy_shows_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busy && csS) |-> (doOe && !doOut));

  // R10: nothing sent while busy moves the write-enable latch
  a_r10_wel_frozen_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(wel));
endmodule

bind mwMemSlave mwMemSlaveChk uChk (
  .clk(clk), .rstN(rstN), .csS(csS), .busy(busy), .wel(wel),
  .doOe(doOe), .doOut(doOut)
);

// File: tb/tb_mwMemSlave.sv
module tb_mwMemSlave;
  localparam int PROG = 400;

  logic clk = 1'b0, rstN = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0, org = 1'b1;
  wire  doOut, doOe;
  int   total = 0, fails = 0;
  bit   welM = 1'b0;
  logic [15:0] model [64];

  always #4 clk = ~clk;

  mwMemSlave #(.PROG_CYCLES(PROG)) dut (
    .clk(clk), .rstN(rstN), .csIn(cs), .skIn(sk), .diIn(di), .orgIn(org),
    .doOut(doOut), .doOe(doOe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int aw();
    return org ? 6 : 7;
  endfunction

  function automatic int dw();
    return org ? 16 : 8;
  endfunction

  function automatic logic [15:0] mRead(input logic [6:0] a);
    if (org) return model[a[5:0]];
    return a[0] ? {8'h00, model[a[6:1]][15:8]} : {8'h00, model[a[6:1]][7:0]};
  endfunction

  function automatic void mWrite(input logic [6:0] a, input logic [15:0] d);
    if (org) model[a[5:0]] = d;
    else if (a[0]) model[a[6:1]][15:8] = d[7:0];
    else model[a[6:1]][7:0] = d[7:0];
  endfunction

  task automatic csUp();
    @(negedge clk);
    cs = 1'b1;
    waitClk(4);
  endtask

  task automatic csDown();
    cs = 1'b0;
    di = 1'b0;
    waitClk(4);
  endtask

  task automatic pulse(input logic b, output logic q);
    di = b;
    waitClk(4);
    sk = 1'b1;
    waitClk(6);
    sk = 1'b0;
    waitClk(4);
    q = doOut;
  endtask

  task automatic sendBits(input logic [31:0] v, input int n);
    logic q;
    for (int i = n - 1; i >= 0; i--) pulse(v[i], q);
  endtask

  task automatic cmd(input logic [1:0] op, input logic [8:0] a, input logic [31:0] d,
                     input int nData);
    csUp();
    sendBits(32'd1, 1);
    sendBits({30'd0, op}, 2);
    sendBits({23'd0, a}, aw());
    if (nData > 0) sendBits(d, nData);
    csDown();
    waitClk(PROG + 20);
  endtask

  function automatic logic [8:0] extAddr(input logic [1:0] sub);
    return org ? {3'd0, sub, 4'd0} : {2'd0, sub, 5'd0};
  endfunction

  task automatic wen();
    cmd(2'b00, extAddr(2'b11), 0, 0);
    welM = 1'b1;
  endtask

  task automatic wds();
    cmd(2'b00, extAddr(2'b00), 0, 0);
    welM = 1'b0;
  endtask

  task automatic writeOp(input logic [6:0] a, input logic [31:0] d, input int n);
    cmd(2'b01, {2'd0, a}, d, n);
    if (welM && n >= dw()) mWrite(a, d[15:0]);
  endtask

  task automatic eraseOp(input logic [6:0] a);
    cmd(2'b11, {2'd0, a}, 0, 0);
    if (welM) mWrite(a, 16'hFFFF);
  endtask

  task automatic wralOp(input logic [15:0] d);
    cmd(2'b00, extAddr(2'b01), {16'd0, d}, dw());
    if (welM) for (int i = 0; i < 64; i++) model[i] = org ? d : {d[7:0], d[7:0]};
  endtask

  task automatic eralOp();
    cmd(2'b00, extAddr(2'b10), 0, 0);
    if (welM) for (int i = 0; i < 64; i++) model[i] = 16'hFFFF;
  endtask

  task automatic readCheck(input logic [6:0] a, input int nWords, input int lead,
                           input string tag);
    logic q;
    logic [15:0] val;
    logic [6:0] cur;
    csUp();
    if (lead > 0) sendBits(0, lead);
    sendBits(32'd1, 1);
    sendBits(32'd2, 2);
    sendBits({26'd0, a >> 1}, aw() - 1);
    pulse(a[0], q);
    chk("R3 dummy zero before data", {31'd0, q}, 0);
    cur = a;
    for (int w = 0; w < nWords; w++) begin
      val = '0;
      for (int b = 0; b < dw(); b++) begin
        pulse(1'b0, q);
        val = {val[14:0], q};
      end
      chk(tag, {16'd0, val}, {16'd0, mRead(cur)});
      cur = org ? {1'b0, cur[5:0] + 6'd1} : cur + 7'd1;
    end
    csDown();
  endtask

  initial begin
    waitClk(190000);
    total++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic q;
    void'($urandom(32'h5EED));
    for (int i = 0; i < 64; i++) model[i] = 16'hFFFF;
    waitClk(5);
    chk("R12 oe low in reset", {31'd0, doOe}, 0);
    rstN = 1'b1;
    waitClk(5);
    chk("R12 oe low after reset", {31'd0, doOe}, 0);
    readCheck(7'd5, 1, 0, "R12 array erased after reset");

    // R5: write before enabling is dropped
    writeOp(7'd3, 32'h1234, 16);
    readCheck(7'd3, 1, 0, "R5 write ignored while latch clear");

    wen();
    // R9 status during and after a program, R10 instruction while busy
    csUp();
    sendBits(32'd1, 1);
    sendBits(32'd1, 2);
    sendBits(32'd3, 6);
    sendBits(32'h1234, 16);
    csDown();
    mWrite(7'd3, 16'h1234);
    waitClk(10);
    csUp();
    chk("R9 busy oe", {31'd0, doOe}, 1);
    chk("R9 busy level", {31'd0, doOut}, 0);
    sendBits(32'd1, 1);
    sendBits(32'd0, 2);
    sendBits(32'd0, 6);  // write disable sent while busy (R10)
    waitClk(PROG);
    chk("R9 ready oe", {31'd0, doOe}, 1);
    chk("R9 ready level", {31'd0, doOut}, 1);
    pulse(1'b1, q);
    chk("R9 status cleared by start bit", {31'd0, doOe}, 0);
    csDown();
    readCheck(7'd3, 1, 0, "R6 word written");
    writeOp(7'd10, 32'hBEEF, 16);
    readCheck(7'd10, 1, 0, "R10 latch kept despite busy instruction");

    // R9: program finished with chip select low
    csUp();
    chk("R9 no status after quiet completion", {31'd0, doOe}, 0);
    csDown();

    // R6: extra data bits and short data
    writeOp(7'd20, 32'hA5678, 20);
    readCheck(7'd20, 1, 0, "R6 last bits kept");
    writeOp(7'd21, 32'h3AA, 10);
    readCheck(7'd21, 1, 0, "R6 short data dropped");

    // random words then a wrapping read over the whole array (R4)
    for (int i = 0; i < 20; i++) writeOp(7'($urandom % 64), 32'($urandom % 65536), 16);
    readCheck(7'd60, 68, 0, "R4 word wrap readback");

    eraseOp(7'd20);
    readCheck(7'd19, 3, 0, "R7 erase one word");
    wralOp(16'hC33C);
    readCheck(7'd62, 4, 0, "R8 write-all word view");
    eralOp();
    readCheck(7'd30, 4, 0, "R7 erase-all");

    // byte view (R2)
    org = 1'b0;
    waitClk(10);
    wralOp(16'h005A);
    readCheck(7'd126, 4, 0, "R8 write-all byte view");
    for (int i = 0; i < 12; i++) writeOp(7'($urandom % 128), 32'($urandom % 256), 8);
    writeOp(7'd127, 32'h77, 8);
    readCheck(7'd120, 16, 0, "R4 byte wrap readback");
    writeOp(7'd8, 32'hC1, 8);
    writeOp(7'd9, 32'h3C, 8);
    eraseOp(7'd11);
    org = 1'b1;
    waitClk(10);
    readCheck(7'd4, 2, 0, "R2 byte lanes seen as words");

    // R5: after write disable nothing changes
    wds();
    writeOp(7'd7, 32'h0F0F, 16);
    eraseOp(7'd4);
    readCheck(7'd4, 4, 0, "R5 program ignored after disable");

    readCheck(7'd10, 1, 2, "R1 leading zeros ignored");
    csUp();
    chk("R11 oe low when idle selected", {31'd0, doOe}, 0);
    csDown();
    chk("R11 oe low when deselected", {31'd0, doOe}, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule